// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Port

This block is a synchronous serial port that moves one 8-bit character out and one 8-bit character in during the same transfer, both shifted on a single shift clock. The CPU side has a transmit-buffer write strobe, a receive-buffer read strobe, a full-duplex enable, a clock-direction select and a clock divider setting. The pin side has serial data out, serial data in and the shift clock. That clock is either generated by the port (master) or taken from the far end (slave).

Receive is double-buffered. A character assembled in the shift register moves to a CPU-visible holding register when its eighth bit arrives, unless that register still holds an unread character. In that case the new character is dropped and an overrun flag is set. Every finished character raises a one-cycle transmit-done pulse. A delivered character also raises a one-cycle receive-done pulse. In master mode the clock stops between characters until the CPU loads the transmit buffer again. In slave mode the port must be loaded before the far end starts clocking, and clock edges that arrive while nothing is loaded set an underrun flag.

Top module: `fdx_sio`

## Requirements
- R1: After reset, sclk_out and sd_out are 1, and tx_full, rx_full, ovr_flag, udr_flag, tx_done and rx_done are 0.
- R2: A tx_wr pulse sets tx_full in the next cycle. tx_full returns to 0 in the cycle after that when the shifter is idle and the character moves into it.
- R3: A character is sent least significant bit first. sd_out presents bit 0 when the character loads and moves to the next bit on each falling shift-clock edge after the first.
- R4: In master mode sclk_out idles at 1 and has a period of cfg_div system clocks, with each half lasting cfg_div/2 clocks. One character takes 8 rising edges.
- R5: Receive data is sampled on rising shift-clock edges, with the first bit received going to bit 0. After the 8th rising edge the character appears on rx_data, rx_full becomes 1 and rx_done pulses for exactly one cycle.
- R6: tx_done pulses for one cycle each time a character finishes, in the same cycle as rx_done when a character is delivered.
- R7: If rx_full is 1 and rx_rd is not asserted when the next character finishes, rx_data keeps the old character, ovr_flag becomes 1, rx_done stays 0 and tx_done still pulses.
- R8: rx_rd clears rx_full. When rx_rd coincides with the cycle in which a character is delivered, the new character is stored and no overrun is flagged.
- R9: In master mode, once a character finishes with the transmit buffer empty, sclk_out stays at 1 until the next tx_wr.
- R10: In slave mode no transfer starts until the transmit buffer is loaded. A shift-clock edge seen while idle with an empty buffer sets udr_flag. clr_udr clears udr_flag and clr_ovr clears ovr_flag.
- R11: In slave mode sclk_in and sd_in pass through a two-flop synchronizer, and a complete character is exchanged in both directions.
- R12: With fdx_en at 0, finished characters are not delivered: rx_full and ovr_flag stay 0, rx_done stays 0, and transmission with tx_done continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: port drives the shift clock; 0: shift clock comes from sclk_in |
| fdx_en | input | 1 | 1: deliver received characters (full duplex) |
| cfg_div | input | DIV_W | Even divider, at least 2, for the master shift clock |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Character to transmit |
| tx_full | output | 1 | Transmit buffer holds a character not yet loaded |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Receive holding register holds an unread character |
| clr_ovr | input | 1 | Clear pulse for ovr_flag |
| clr_udr | input | 1 | Clear pulse for udr_flag |
| ovr_flag | output | 1 | Sticky receive overrun flag |
| udr_flag | output | 1 | Sticky slave transmit underrun flag |
| tx_done | output | 1 | One-cycle pulse at the end of each character |
| rx_done | output | 1 | One-cycle pulse when a character is delivered |
| sclk_in | input | 1 | External shift clock (slave mode) |
| sclk_out | output | 1 | Generated shift clock (master mode), idles at 1 |
| sclk_oe | output | 1 | Output enable for the shift clock pin |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |

## Verification
The interesting collision is a CPU read of the receive buffer landing in the same cycle as the delivery of the next character. The read frees the buffer and the delivery fills it, so the question is whether the character survives or is counted as an overrun. The bench leaves an older character unread and starts a new character. It then watches sclk_out and asserts rx_rd exactly in the cycle after the eighth rising edge, which is the cycle in which the port hands the character over. It judges the result by the scoreboard seeing the new character on rx_data together with rx_done and tx_done, and by ovr_flag staying 0.

// File: rtl/fdx_sio_pkg.sv
package fdx_sio_pkg;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = $clog2(CHAR_W + 1);
  typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/fdx_sio_clkgen.sv
// Shift-clock source: divider for master mode, synchronizer plus edge
// detector for slave mode. Also synchronizes serial data in.
module fdx_sio_clkgen #(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             busy,
  input  logic             sclk_in,
  input  logic             sd_in,
  output logic             sclk_out,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             din_sync
);
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  half_m1;
  logic              sclk_q;
  logic              tick;
  logic [SYNC_N:0]   ck_sh;
  logic [SYNC_N-1:0] d_sh;
  logic              s_rise, s_fall;

  assign half_m1 = (cfg_div >> 1) - 1'b1;
  assign tick    = master && busy && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !master || !busy) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // ck_sh[0] is the newest sample; ck_sh[SYNC_N-1] is the synchronized level
  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh <= '1;
      d_sh  <= '0;
    end else begin
      ck_sh <= {ck_sh[SYNC_N-1:0], sclk_in};
      d_sh  <= {d_sh[SYNC_N-2:0], sd_in};
    end
  end

  assign s_rise   = ck_sh[SYNC_N-1] & ~ck_sh[SYNC_N];
  assign s_fall   = ~ck_sh[SYNC_N-1] & ck_sh[SYNC_N];
  assign din_sync = d_sh[SYNC_N-1];
  assign sclk_out = sclk_q;
  assign fall_ev  = master ? (tick & sclk_q)  : s_fall;
  assign rise_ev  = master ? (tick & ~sclk_q) : s_rise;
endmodule

// File: rtl/fdx_sio_shift.sv
// Combined transmit/receive shift register, LSB first.
module fdx_sio_shift
  import fdx_sio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  char_t load_data,
  input  logic  fall_ev,
  input  logic  rise_ev,
  input  logic  din,
  output logic  busy,
  output logic  sd_out,
  output logic  done,
  output char_t rx_word
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic             busy_q, sd_q, done_q;
  logic [CNT_W-1:0] bit_cnt;
  char_t            tx_sr, rx_sr;

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst) begin
      busy_q  <= 1'b0;
      sd_q    <= 1'b1;
      bit_cnt <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else if (!busy_q) begin
      if (load) begin
        busy_q  <= 1'b1;
        tx_sr   <= load_data;
        sd_q    <= load_data[0];
        bit_cnt <= '0;
      end
    end else begin
      if (fall_ev && bit_cnt != '0) begin
        sd_q  <= tx_sr[1];
        tx_sr <= tx_sr >> 1;
      end
      if (rise_ev) begin
        rx_sr   <= {din, rx_sr[CHAR_W-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          sd_q   <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sd_out  = sd_q;
  assign done    = done_q;
  assign rx_word = rx_sr;
endmodule

// File: rtl/fdx_sio.sv
module fdx_sio
  import fdx_sio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              fdx_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_wr,
  input  logic [CHAR_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_rd,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_full,
  input  logic              clr_ovr,
  input  logic              clr_udr,
  output logic              ovr_flag,
  output logic              udr_flag,
  output logic              tx_done,
  output logic              rx_done,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sd_in,
  output logic              sd_out
);
  char_t tx_buf, rx_buf, rx_word;
  logic  txf_q, rxf_q, ovr_q, udr_q, txd_q, rxd_q;
  logic  busy, load, done, fall_ev, rise_ev, din_sync, din;
  logic  accept, udr_set;

  fdx_sio_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
    .clk(clk), .rst(rst), .master(cfg_master), .cfg_div(cfg_div),
    .busy(busy), .sclk_in(sclk_in), .sd_in(sd_in), .sclk_out(sclk_out),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .din_sync(din_sync)
  );

  fdx_sio_shift u_shift (
    .clk(clk), .rst(rst), .load(load), .load_data(tx_buf),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .din(din),
    .busy(busy), .sd_out(sd_out), .done(done), .rx_word(rx_word)
  );

  assign din     = cfg_master ? sd_in : din_sync;
  assign load    = txf_q && !busy;
  assign accept  = done && fdx_en && (!rxf_q || rx_rd);
  assign udr_set = !cfg_master && !busy && !txf_q && (rise_ev || fall_ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf <= '0;
      txf_q  <= 1'b0;
    end else begin
      if (load)  txf_q <= 1'b0;
      if (tx_wr) begin
        tx_buf <= tx_data;
        txf_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    rxd_q <= 1'b0;
    txd_q <= 1'b0;
    if (rst) begin
      rx_buf <= '0;
      rxf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      txd_q <= done;
      if (rx_rd) rxf_q <= 1'b0;
      if (accept) begin
        rx_buf <= rx_word;
        rxf_q  <= 1'b1;
        rxd_q  <= 1'b1;
      end
      if (clr_ovr) ovr_q <= 1'b0;
      if (done && fdx_en && !accept) ovr_q <= 1'b1;
      if (clr_udr) udr_q <= 1'b0;
      if (udr_set) udr_q <= 1'b1;
    end
  end

  assign tx_full  = txf_q;
  assign rx_full  = rxf_q;
  assign rx_data  = rx_buf;
  assign ovr_flag = ovr_q;
  assign udr_flag = udr_q;
  assign tx_done  = txd_q;
  assign rx_done  = rxd_q;
  assign sclk_oe  = cfg_master;
endmodule

// File: rtl/fdx_sio_chk.sv
module fdx_sio_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_master,
  input logic       fdx_en,
  input logic       tx_wr,
  input logic       tx_full,
  input logic       rx_rd,
  input logic       rx_full,
  input logic [7:0] rx_data,
  input logic       rx_done,
  input logic       tx_done,
  input logic       sclk_out,
  input logic       udr_flag,
  input logic       busy
);
  p_txfull_set_r2: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> tx_full);

  p_rx_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);

  p_done_pair_r6: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> tx_done);

  p_keep_old_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd) |=> $stable(rx_data));

  p_stall_high_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && !busy && !tx_full) |=> sclk_out);

  p_udr_slave_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(udr_flag) |-> !$past(cfg_master));

  p_no_deliver_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(fdx_en) |-> !rx_done);
endmodule

bind fdx_sio fdx_sio_chk u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .fdx_en(fdx_en),
  .tx_wr(tx_wr), .tx_full(tx_full), .rx_rd(rx_rd), .rx_full(rx_full),
  .rx_data(rx_data), .rx_done(rx_done), .tx_done(tx_done),
  .sclk_out(sclk_out), .udr_flag(udr_flag), .busy(busy)
);

// File: tb/fdx_sio_bench.sv
module fdx_sio_bench;
  logic clk = 0, rst = 1;
  logic cfg_master = 1, fdx_en = 1;
  logic [7:0] cfg_div = 8'd4;
  logic tx_wr = 0, rx_rd = 0, clr_ovr = 0, clr_udr = 0;
  logic [7:0] tx_data = 0;
  logic sclk_in = 1, sd_slave = 1, lb_inv = 0;
  logic tx_full, rx_full, ovr_flag, udr_flag, tx_done, rx_done;
  logic sclk_out, sclk_oe, sd_out, sd_in;
  logic [7:0] rx_data;

  int tests = 0, fails = 0, cyc = 0;
  int rx_cnt = 0, tx_cnt = 0, low_cnt = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;
  assign sd_in = cfg_master ? (sd_out ^ lb_inv) : sd_slave;

  fdx_sio u_fdx_sio (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .fdx_en(fdx_en),
    .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .clr_ovr(clr_ovr),
    .clr_udr(clr_udr), .ovr_flag(ovr_flag), .udr_flag(udr_flag),
    .tx_done(tx_done), .rx_done(rx_done), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sd_in(sd_in), .sd_out(sd_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pops on every delivered character
  logic rx_prev = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!cfg_master || 1) if (sclk_out == 0) low_cnt++;
      if (tx_done) tx_cnt++;
      if (rx_done) begin
        rx_cnt++;
        chk("R6 tx_done with rx_done", tx_done, 1);
        chk("R5 rx_done one cycle", rx_prev, 0);
        if (exp_q.size() == 0) chk("R5 unexpected delivery", 1, 0);
        else chk("R5 rx_data", rx_data, exp_q.pop_front());
      end
      rx_prev = rx_done;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk) tx_wr = 1; tx_data = d;
    @(negedge clk) tx_wr = 0;
  endtask

  task automatic wait_tx_done();
    int start = tx_cnt;
    for (int i = 0; i < 2000 && tx_cnt == start; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic read_rx();
    @(negedge clk) rx_rd = 1;
    @(negedge clk) rx_rd = 0;
    chk("R8 rx_rd clears rx_full", rx_full, 0);
  endtask

  task automatic slave_frame(input logic [7:0] drv, output logic [7:0] cap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) sclk_in = 0; sd_slave = drv[i];
      repeat (8) @(negedge clk);
      cap[i] = sd_out;
      sclk_in = 1;
      repeat (8) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] cap;
    int lc, txc, rxc, n;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 sd_out", sd_out, 1);
    chk("R1 flags", {tx_full, rx_full, ovr_flag, udr_flag, tx_done, rx_done}, 0);

    // R2/R3/R4/R5 master loopback, divider 4
    exp_q.push_back(8'hA5);
    lc = low_cnt;
    @(negedge clk) tx_wr = 1; tx_data = 8'hA5;
    @(negedge clk) tx_wr = 0;
    chk("R2 tx_full set", tx_full, 1);
    chk("R3 bit0 on load", sd_out, 1);
    @(negedge clk);
    chk("R2 tx_full cleared on load", tx_full, 0);
    wait_tx_done();
    chk("R4 low cycles div4", low_cnt - lc, 16);
    chk("R5 rx_full", rx_full, 1);
    read_rx();

    // R9 stall with empty buffer
    lc = low_cnt;
    repeat (40) @(negedge clk);
    chk("R9 clock held idle", low_cnt - lc, 0);
    chk("R9 sclk_out high", sclk_out, 1);

    // R7 overrun
    exp_q.push_back(8'h11);
    write_tx(8'h11);
    wait_tx_done();
    rxc = rx_cnt; txc = tx_cnt;
    write_tx(8'h22);
    wait_tx_done();
    chk("R7 old char kept", rx_data, 8'h11);
    chk("R7 overrun flag", ovr_flag, 1);
    chk("R7 no rx_done", rx_cnt - rxc, 0);
    chk("R7 tx_done still", tx_cnt - txc, 1);
    @(negedge clk) clr_ovr = 1;
    @(negedge clk) clr_ovr = 0;
    chk("R10 clr_ovr clears", ovr_flag, 0);

    // R8 read coinciding with delivery (buffer still holds 0x11)
    exp_q.push_back(8'h5A);
    write_tx(8'h5A);
    n = 0; prev = 1;
    for (int i = 0; i < 500 && n < 8; i++) begin
      @(negedge clk);
      if (sclk_out && !prev) n++;
      prev = sclk_out;
    end
    rx_rd = 1;
    @(negedge clk) rx_rd = 0;
    chk("R8 coincident delivery", rx_done, 1);
    chk("R8 no overrun", ovr_flag, 0);
    read_rx();

    // R4/R5 divider 6 with inverted loopback
    cfg_div = 8'd6; lb_inv = 1;
    exp_q.push_back(8'h3C);
    lc = low_cnt;
    write_tx(8'hC3);
    wait_tx_done();
    chk("R4 low cycles div6", low_cnt - lc, 24);
    read_rx();
    lb_inv = 0;

    // R12 full duplex disabled
    fdx_en = 0;
    rxc = rx_cnt; txc = tx_cnt;
    write_tx(8'h77);
    wait_tx_done();
    chk("R12 tx_done continues", tx_cnt - txc, 1);
    chk("R12 no rx_done", rx_cnt - rxc, 0);
    chk("R12 rx_full stays 0", rx_full, 0);
    chk("R12 no overrun", ovr_flag, 0);
    fdx_en = 1;

    // R10 slave underrun
    cfg_master = 0; cfg_div = 8'd4;
    repeat (4) @(negedge clk);
    rxc = rx_cnt; txc = tx_cnt;
    sclk_in = 0; repeat (8) @(negedge clk);
    sclk_in = 1; repeat (8) @(negedge clk);
    chk("R10 underrun flag", udr_flag, 1);
    chk("R10 no transfer without load", tx_cnt - txc, 0);
    chk("R10 sclk_oe off in slave", sclk_oe, 0);
    @(negedge clk) clr_udr = 1;
    @(negedge clk) clr_udr = 0;
    chk("R10 clr_udr clears", udr_flag, 0);

    // R11/R3 slave exchange
    exp_q.push_back(8'h4B);
    write_tx(8'h96);
    @(negedge clk);
    chk("R2 slave load", tx_full, 0);
    slave_frame(8'h4B, cap);
    chk("R3 LSB-first captured", cap, 8'h96);
    chk("R11 slave rx_full", rx_full, 1);
    chk("R10 no underrun while loaded", udr_flag, 0);
    read_rx();

    repeat (10) @(negedge clk);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule